// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns a logical address into a physical address. The upper bits of the logical address form a page number and the lower bits form an offset. The page number is looked up in a small fully associative translation cache. On a cache miss, the block reads one entry from a single-level page table in external memory. A table base register and a table length register locate and bound that table. Software reloads both registers whenever the running process changes.

A request carries a logical address and an access kind: read, write or instruction fetch. The request is accepted with a valid/ready handshake, and only one request is in flight at a time. Every accepted request ends in one `done` strobe. The strobe comes with either a physical address or a fault code. The block checks the page number against the table length, the entry's valid bit and the entry's permission field, so protection is enforced on the same path that produces the address.

Top module: `xlat_mmu`

## Requirements
- R1: On a translation with no fault, `paddr` equals the frame number from the page-table entry in the upper bits, followed by the unchanged offset (the low `OFF_W` bits of `req_vaddr`) in the lower bits.
- R2: A request whose page is held in the translation cache completes with `done` in the cycle after acceptance and issues no memory read.
- R3: A cache miss issues exactly one memory read. The read is a single-cycle `mem_rd_en` pulse in the cycle after acceptance, at word address `tbl_base + page number`. `done` rises in the cycle after `mem_rd_valid`.
- R4: A page number greater than or equal to the table length produces fault code 1 (bounds) with `done` in the cycle after acceptance, and no memory read is issued.
- R5: A page-table entry with bit 0 (valid) clear produces fault code 2 (invalid). Such an entry is never cached, so a repeat request for that page reads memory again.
- R6: Entry bits 2:1 hold the permission, and `req_acc` encodes the access kind (0 read, 1 write, 2 fetch). The permitted accesses are:
  - 00 (read-only) permits read only.
  - 01 (execute-only) permits fetch only.
  - 10 (read/write) permits read and write.
  - 11 permits nothing.
  A disallowed access produces fault code 3 (protection). Fault code 0 means success.
- R7: A miss whose entry is valid stores the page in the cache, so the next request to that page is a hit. The frame number is in entry bits `3+FRAME_W-1:3`.
- R8: Fills replace cache slots in round-robin order. After `TLB_N` distinct fills following a flush, one more fill evicts the page filled first.
- R9: Writing the table base register (`tbl_base_we`) invalidates every cache entry. Writing the table length register does not.
- R10: `req_ready` is high whenever no walk is outstanding, including just after reset. It is low from the cycle after a miss is accepted until the walk completes.
- R11: Whenever `done` is high with a nonzero fault code, `paddr` is zero. After reset, `done` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Logical address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| tbl_base_we | input | 1 | Load table base; flushes the cache |
| tbl_base | input | MA_W | New page-table base word address |
| tbl_len_we | input | 1 | Load table length |
| tbl_len | input | VPN_W+1 | New number of table entries |
| mem_rd_en | output | 1 | Page-table read strobe |
| mem_rd_addr | output | MA_W | Page-table entry word address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | PTE_W | Page-table entry |
| done | output | 1 | Result strobe, one cycle |
| paddr | output | PA_W | Physical address, zero on fault |
| fault | output | 2 | 0 none, 1 bounds, 2 invalid, 3 protection |

## Verification
Hits and bounds faults must show `done` exactly one cycle after the accepting edge. A miss must show its read strobe one cycle after acceptance and `done` one cycle after the memory model returns data. The memory model answers three cycles after it sees the read. The bench records the cycle of acceptance, of the read strobe and of the read response, and the monitor compares the cycle of each `done` against these. It also counts the read strobes seen between results, so a hit that reads memory, or a miss that reads twice, is reported.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_RD = 2'd0,
        ACC_WR = 2'd1,
        ACC_EX = 2'd2,
        ACC_XX = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        PERM_RO   = 2'd0,
        PERM_XO   = 2'd1,
        PERM_RW   = 2'd2,
        PERM_NONE = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_BOUNDS  = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_PROT    = 2'd3
    } fault_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } state_e;

    // entry layout: valid at bit 0, permission at 2:1, frame from bit 3 upward
    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_PERM_LSB  = 1;
    localparam int PTE_FRAME_LSB = 3;

    function automatic logic perm_allows(acc_e a, perm_e p);
        case (a)
            ACC_RD:  return (p == PERM_RO) || (p == PERM_RW);
            ACC_WR:  return (p == PERM_RW);
            ACC_EX:  return (p == PERM_XO);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xlat_check.sv
module xlat_check
    import xlat_pkg::*;
(
    input  acc_e   acc,
    input  perm_e  perm,
    input  logic   ent_valid,
    output fault_e flt
);
    always_comb begin
        if (!ent_valid)
            flt = FLT_INVALID;
        else if (!perm_allows(acc, perm))
            flt = FLT_PROT;
        else
            flt = FLT_NONE;
    end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int N       = 64,
    parameter int VPN_W   = 8,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               hit,
    output logic [FRAME_W-1:0] hit_frame,
    output perm_e              hit_perm,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [FRAME_W-1:0] fill_frame,
    input  perm_e              fill_perm
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]       ent_v;
    logic [VPN_W-1:0]   ent_vpn   [N];
    logic [FRAME_W-1:0] ent_frame [N];
    logic [1:0]         ent_perm  [N];
    logic [IDX_W-1:0]   victim;
    logic [N-1:0]       match;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ent_v <= '0;
        end else if (fill_en) begin
            for (int i = 0; i < N; i++) begin
                if (victim == IDX_W'(i)) begin
                    ent_v[i]     <= 1'b1;
                    ent_vpn[i]   <= fill_vpn;
                    ent_frame[i] <= fill_frame;
                    ent_perm[i]  <= fill_perm;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            victim <= '0;
        else if (fill_en && !flush)
            victim <= (victim == IDX_W'(N - 1)) ? '0 : victim + 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign match[g] = ent_v[g] && (ent_vpn[g] == lk_vpn);
        end
    endgenerate

    // at most one slot matches: fills happen only on a miss
    always_comb begin
        logic [1:0] p;
        hit_frame = '0;
        p         = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                hit_frame = hit_frame | ent_frame[i];
                p         = p | ent_perm[i];
            end
        end
        hit      = |match;
        hit_perm = perm_e'(p);
    end
endmodule

// File: rtl/xlat_mmu.sv
module xlat_mmu
    import xlat_pkg::*;
#(
    parameter int VA_W  = 16,
    parameter int OFF_W = 8,
    parameter int PA_W  = 16,
    parameter int MA_W  = 16,
    parameter int PTE_W = 16,
    parameter int TLB_N = 64,
    localparam int VPN_W   = VA_W - OFF_W,
    localparam int FRAME_W = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic             tbl_base_we,
    input  logic [MA_W-1:0]  tbl_base,
    input  logic             tbl_len_we,
    input  logic [VPN_W:0]   tbl_len,
    output logic             mem_rd_en,
    output logic [MA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [PTE_W-1:0] mem_rd_data,
    output logic             done,
    output logic [PA_W-1:0]  paddr,
    output logic [1:0]       fault
);
    state_e             state;
    logic [MA_W-1:0]    base_q;
    logic [VPN_W:0]     tbl_len_q;
    logic [VPN_W-1:0]   cur_vpn;
    logic [OFF_W-1:0]   cur_off;
    acc_e               cur_acc;
    logic               done_q;
    logic [PA_W-1:0]    paddr_q;
    fault_e             fault_q;
    logic               rd_en_q;
    logic [MA_W-1:0]    rd_addr_q;

    logic [VPN_W-1:0]   in_vpn;
    logic [OFF_W-1:0]   in_off;
    logic               accept;
    logic               out_of_range;

    logic               t_hit;
    logic [FRAME_W-1:0] t_frame;
    perm_e              t_perm;

    logic               pte_valid;
    perm_e              pte_perm;
    logic [FRAME_W-1:0] pte_frame;

    acc_e               chk_acc;
    perm_e              chk_perm;
    logic               chk_valid;
    fault_e             chk_flt;
    logic               fill_en;

    assign in_vpn       = req_vaddr[VA_W-1:OFF_W];
    assign in_off       = req_vaddr[OFF_W-1:0];
    assign req_ready    = (state == ST_IDLE);
    assign accept       = req_valid && req_ready;
    assign out_of_range = ({1'b0, in_vpn} >= tbl_len_q);

    assign pte_valid = mem_rd_data[PTE_VALID_BIT];
    assign pte_perm  = perm_e'(mem_rd_data[PTE_PERM_LSB +: 2]);
    assign pte_frame = mem_rd_data[PTE_FRAME_LSB +: FRAME_W];

    // one checker shared by the hit path (idle) and the walk return
    assign chk_acc   = (state == ST_WALK) ? cur_acc  : acc_e'(req_acc);
    assign chk_perm  = (state == ST_WALK) ? pte_perm : t_perm;
    assign chk_valid = (state == ST_WALK) ? pte_valid : 1'b1;
    assign fill_en   = (state == ST_WALK) && mem_rd_valid && pte_valid;

    xlat_tlb #(
        .N       (TLB_N),
        .VPN_W   (VPN_W),
        .FRAME_W (FRAME_W)
    ) u_tlb (
        .clk        (clk),
        .rst        (rst),
        .flush      (tbl_base_we),
        .lk_vpn     (in_vpn),
        .hit        (t_hit),
        .hit_frame  (t_frame),
        .hit_perm   (t_perm),
        .fill_en    (fill_en),
        .fill_vpn   (cur_vpn),
        .fill_frame (pte_frame),
        .fill_perm  (pte_perm)
    );

    xlat_check u_check (
        .acc       (chk_acc),
        .perm      (chk_perm),
        .ent_valid (chk_valid),
        .flt       (chk_flt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            base_q    <= '0;
            tbl_len_q <= '0;
            cur_vpn   <= '0;
            cur_off   <= '0;
            cur_acc   <= ACC_RD;
            done_q    <= 1'b0;
            paddr_q   <= '0;
            fault_q   <= FLT_NONE;
            rd_en_q   <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            done_q  <= 1'b0;
            rd_en_q <= 1'b0;
            if (tbl_base_we) base_q    <= tbl_base;
            if (tbl_len_we)  tbl_len_q <= tbl_len;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cur_vpn <= in_vpn;
                        cur_off <= in_off;
                        cur_acc <= acc_e'(req_acc);
                        if (out_of_range) begin
                            done_q  <= 1'b1;
                            fault_q <= FLT_BOUNDS;
                            paddr_q <= '0;
                        end else if (t_hit) begin
                            done_q  <= 1'b1;
                            fault_q <= chk_flt;
                            paddr_q <= (chk_flt == FLT_NONE) ? {t_frame, in_off} : '0;
                        end else begin
                            rd_en_q   <= 1'b1;
                            rd_addr_q <= base_q + MA_W'(in_vpn);
                            state     <= ST_WALK;
                        end
                    end
                end
                ST_WALK: begin
                    if (mem_rd_valid) begin
                        done_q  <= 1'b1;
                        fault_q <= chk_flt;
                        paddr_q <= (chk_flt == FLT_NONE) ? {pte_frame, cur_off} : '0;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd_en   = rd_en_q;
    assign mem_rd_addr = rd_addr_q;
    assign done        = done_q;
    assign paddr       = paddr_q;
    assign fault       = fault_q;
endmodule

// File: rtl/xlat_mmu_chk.sv
module xlat_mmu_chk #(
    parameter int VA_W  = 16,
    parameter int OFF_W = 8,
    parameter int PA_W  = 16,
    localparam int VPN_W = VA_W - OFF_W
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic [VPN_W:0]  tbl_len_q,
    input logic            mem_rd_en,
    input logic            mem_rd_valid,
    input logic            done,
    input logic [PA_W-1:0] paddr,
    input logic [1:0]      fault
);
    a_r4_bounds_no_read: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && ({1'b0, req_vaddr[VA_W-1:OFF_W]} >= tbl_len_q))
        |=> (done && fault == 2'd1 && !mem_rd_en));

    a_r3_single_read: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    a_r10_busy_in_walk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> !req_ready);

    a_r3_done_after_data: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !req_ready) |=> done);

    a_r11_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 2'd0) |-> (paddr == '0));

    a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (done != mem_rd_en));
endmodule

bind xlat_mmu xlat_mmu_chk #(
    .VA_W  (VA_W),
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .tbl_len_q    (tbl_len_q),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_valid (mem_rd_valid),
    .done         (done),
    .paddr        (paddr),
    .fault        (fault)
);

// File: tb/test_xlat_mmu.sv
module test_xlat_mmu;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;
    localparam int TLB_N      = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        tbl_base_we = 1'b0;
    logic [15:0] tbl_base = '0;
    logic        tbl_len_we = 1'b0;
    logic [8:0]  tbl_len = '0;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic        done;
    logic [15:0] paddr;
    logic [1:0]  fault;

    xlat_mmu #(.TLB_N(TLB_N)) i_xlat_mmu (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .tbl_base_we(tbl_base_we),
        .tbl_base(tbl_base), .tbl_len_we(tbl_len_we), .tbl_len(tbl_len),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .done(done), .paddr(paddr), .fault(fault)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [15:0] exp_paddr;
        logic [1:0]  exp_fault;
        bit          miss;
        logic [15:0] exp_rd_addr;
        int          acc_cyc;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [15:0] base_model = '0;

    int rd_cnt = 0, rd_cyc = 0, resp_cyc = 0, wait_cnt = 0;
    bit pend = 0;
    logic [15:0] rd_addr_seen = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // entry format: valid bit 0, permission bits 2:1, frame bits 10:3
    function automatic logic [15:0] pte_of(input int vpn);
        logic [7:0] fr;
        logic [1:0] pm;
        logic       v;
        v = 1'b1; pm = 2'd2; fr = 8'(vpn) ^ 8'h55;
        case (vpn)
            3: fr = 8'h2A;
            5: v = 1'b0;
            6: begin pm = 2'd0; fr = 8'h61; end
            7: begin pm = 2'd1; fr = 8'h71; end
            8: begin pm = 2'd3; fr = 8'h81; end
            default: ;
        endcase
        return {5'b0, fr, pm, v};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // memory model and result monitor
    always @(negedge clk) begin
        if (rst) begin
            mem_rd_valid = 1'b0;
            pend = 0;
        end else begin
            mem_rd_valid = 1'b0;
            if (mem_rd_en) begin
                pend = 1; wait_cnt = MEM_LAT; rd_addr_seen = mem_rd_addr;
                rd_cyc = cyc; rd_cnt++;
            end else if (pend) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data = pte_of(int'(rd_addr_seen - base_model));
                    resp_cyc = cyc;
                    pend = 0;
                end
            end
            if (done) begin
                if (sb.size() == 0) begin
                    check(0, "R2", "unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(paddr == it.exp_paddr, it.tag, "paddr", paddr, it.exp_paddr);
                    check(fault == it.exp_fault, it.tag, "fault", fault, it.exp_fault);
                    check(rd_cnt == (it.miss ? 1 : 0), it.tag, "read count", rd_cnt, it.miss ? 1 : 0);
                    if (it.miss) begin
                        check(rd_addr_seen == it.exp_rd_addr, "R3", "read addr", rd_addr_seen, it.exp_rd_addr);
                        check(rd_cyc == it.acc_cyc + 1, "R3", "read cycle", rd_cyc, it.acc_cyc + 1);
                        check(cyc == resp_cyc + 1, "R3", "done cycle", cyc, resp_cyc + 1);
                    end else begin
                        check(cyc == it.acc_cyc + 1, it.tag, "done cycle", cyc, it.acc_cyc + 1);
                    end
                end
                rd_cnt = 0;
            end
        end
    end

    task automatic do_req(input int vpn, input int off, input logic [1:0] acc,
                          input bit miss, input logic [1:0] flt, input logic [7:0] fr,
                          input string tag);
        item_t it;
        it.exp_paddr   = (flt == 2'd0) ? {fr, 8'(off)} : 16'h0;
        it.exp_fault   = flt;
        it.miss        = miss;
        it.exp_rd_addr = base_model + 16'(vpn);
        it.tag         = tag;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {8'(vpn), 8'(off)};
        req_acc   = acc;
        it.acc_cyc = cyc;
        sb.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        if (miss) check(req_ready == 1'b0, "R10", "ready during walk", req_ready, 0);
        else      check(req_ready == 1'b1, "R10", "ready after hit", req_ready, 1);
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic set_base(input logic [15:0] b);
        @(negedge clk);
        tbl_base_we = 1'b1; tbl_base = b; base_model = b;
        @(negedge clk);
        tbl_base_we = 1'b0;
    endtask

    task automatic set_len(input int l);
        @(negedge clk);
        tbl_len_we = 1'b1; tbl_len = 9'(l);
        @(negedge clk);
        tbl_len_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 R10: reset state
        check(done == 1'b0, "R11", "done after reset", done, 0);
        check(mem_rd_en == 1'b0, "R11", "rd_en after reset", mem_rd_en, 0);
        check(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);

        set_base(16'h0100);
        set_len(16);

        // R1 R3 R7: miss then hit on the same page
        do_req(3, 8'h5C, 2'd0, 1, 2'd0, 8'h2A, "R3");
        do_req(3, 8'hE1, 2'd1, 0, 2'd0, 8'h2A, "R7");
        do_req(3, 8'h00, 2'd0, 0, 2'd0, 8'h2A, "R1");
        // R4: bounds
        do_req(20, 8'h11, 2'd0, 0, 2'd1, 8'h00, "R4");
        do_req(16, 8'h11, 2'd0, 0, 2'd1, 8'h00, "R4");
        do_req(15, 8'hFF, 2'd0, 1, 2'd0, 8'h55 ^ 8'd15, "R1");
        // R5: invalid entry, not cached
        do_req(5, 8'h22, 2'd0, 1, 2'd2, 8'h00, "R5");
        do_req(5, 8'h22, 2'd0, 1, 2'd2, 8'h00, "R5");
        // R6: permissions
        do_req(6, 8'h33, 2'd0, 1, 2'd0, 8'h61, "R6");
        do_req(6, 8'h33, 2'd1, 0, 2'd3, 8'h00, "R6");
        do_req(6, 8'h33, 2'd2, 0, 2'd3, 8'h00, "R6");
        do_req(7, 8'h44, 2'd2, 1, 2'd0, 8'h71, "R6");
        do_req(7, 8'h44, 2'd0, 0, 2'd3, 8'h00, "R6");
        do_req(8, 8'h55, 2'd2, 1, 2'd3, 8'h00, "R6");
        do_req(3, 8'h66, 2'd2, 0, 2'd3, 8'h00, "R6");
        // R9: length write keeps cache, base write flushes it
        set_len(16);
        do_req(3, 8'h77, 2'd1, 0, 2'd0, 8'h2A, "R9");
        set_base(16'h0100);
        do_req(3, 8'h77, 2'd1, 1, 2'd0, 8'h2A, "R9");
        // R8: round-robin replacement
        set_len(100);
        set_base(16'h0100);
        for (int p = 10; p < 10 + TLB_N; p++)
            do_req(p, 8'h01, 2'd0, 1, 2'd0, 8'(p) ^ 8'h55, "R8");
        do_req(10, 8'h02, 2'd0, 0, 2'd0, 8'd10 ^ 8'h55, "R8");
        do_req(10 + TLB_N, 8'h03, 2'd0, 1, 2'd0, 8'(10 + TLB_N) ^ 8'h55, "R8");
        do_req(11, 8'h04, 2'd0, 0, 2'd0, 8'd11 ^ 8'h55, "R8");
        do_req(10, 8'h05, 2'd0, 1, 2'd0, 8'd10 ^ 8'h55, "R8");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule